// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits in front of a memory target that several bus initiators share, and it decides the outcome of each access. Every access arrives as one simplified request: a valid strobe, a direction, an exclusive flag, a transaction ID, a start byte address and a byte length. For each request the block returns a response code and a write-enable for the memory array. The write-enable lets the memory update happen or stops it.

An exclusive read places a reservation on the range of bytes it covers. The reservation is tagged with the ID of the request and kept in a small table. A later exclusive write from the same ID succeeds only when that reservation is still intact and covers exactly the same bytes. If any allowed write has touched an overlapping byte since the read, the reservation is gone and the exclusive write fails with no update. Plain reads and writes are always answered at once. They never stall or lock anything, so no initiator holds the memory while it works out a read-modify-write.

A parameter removes exclusive support. In that build the exclusive flag is ignored and every access is treated as an ordinary one.

Top module: `excl_mon`

## Requirements
- R1: An exclusive read returns EXOKAY (code 2'b01) and reserves, for its ID, the byte range from addr to addr+len. Here len is the byte count minus one.
- R2: An exclusive write returns EXOKAY with mem_wr_en high when three things hold: its ID has a valid reservation, that reservation's start equals the write's start, and its end equals the write's end.
- R3: Any other exclusive write returns OKAY (code 2'b00) with mem_wr_en low. This covers an ID with no reservation, a range that differs from the reserved one, and a reservation that was lost.
- R4: A non-exclusive read returns OKAY with mem_wr_en low. A non-exclusive write returns OKAY with mem_wr_en high.
- R5: Every write that raises mem_wr_en clears each reservation, of any ID, whose range shares at least one byte with the written range. This includes the writer's own reservation.
- R6: An exclusive read from an ID that already holds a reservation replaces that reservation's range and takes no new table entry.
- R7: Different IDs may hold reservations on the same or overlapping bytes at once. Reserving one ID leaves the reservations of other IDs unchanged.
- R8: Non-exclusive reads never change any reservation. A reservation that is never used stays until rule R5 or rule R6 removes it, or until an eviction under R9.
- R9: A reservation for a new ID goes into the lowest-numbered free entry. When all entries are in use, the new reservation evicts the entry at a victim pointer. The pointer starts at entry 0 after reset and moves to the next entry, wrapping round, after each eviction.
- R10: With EXCL_EN = 0, exclusive reads return OKAY and reserve nothing. Exclusive writes return OKAY and behave as plain writes, so mem_wr_en is high.
- R11: rsp_valid, rsp_code and mem_wr_en answer a request one clock after it is presented. rsp_valid is low in any cycle that follows a cycle with no request.
- R12: While rst_n is low, synchronously, all reservations are dropped, the victim pointer returns to 0 and all outputs go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_excl | input | 1 | Exclusive access flag |
| req_id | input | ID_W | Transaction ID of the initiator |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count minus one |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 2'b00 OKAY, 2'b01 EXOKAY |
| mem_wr_en | output | 1 | Allows the memory write for the answered request |

## Verification
Random traffic uses six IDs against four entries over a small address window. Overlaps and evictions therefore happen all the time, and this separates a clear that checks for overlap from one that compares exact ranges, and an eviction by victim pointer from one by free slot. About a third of the exclusive writes copy a range the model still holds, so both successful and failed exclusive writes occur in large numbers. Directed sequences isolate specific cases: a write by another ID that breaks a reservation, a replace by the same ID, two IDs on one region, an off-by-one range, and a full table. A second instance built without exclusive support receives the same stimulus, which shows that the exclusive flag is truly ignored there.

// File: rtl/excl_mon_pkg.sv
// Shared response codes for the exclusive access reservation monitor.
package excl_mon_pkg;
    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_EXOKAY = 2'b01
    } rsp_e;
endpackage

// File: rtl/excl_mon_entry.sv
// One reservation slot: keeps ID, first and last byte of a reserved range.
// It drops itself when an allowed write overlaps that range.
// Assumes the controller never asks for a set and an allowed write in one cycle.
module excl_mon_entry #(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              wclr_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [ADDR_W:0]   first_i,
    input  logic [ADDR_W:0]   last_i,
    output logic              valid_o,
    output logic              id_hit_o,
    output logic              exact_o
);
    logic [ID_W-1:0] id_q;
    logic [ADDR_W:0] first_q;
    logic [ADDR_W:0] last_q;
    logic            overlap;

    // Compare the held reservation with the current request.
    always_comb begin
        id_hit_o = valid_o && (id_q == id_i);
        exact_o  = id_hit_o && (first_q == first_i) && (last_q == last_i);
        overlap  = valid_o && (first_q <= last_i) && (first_i <= last_q);
    end

    // Load a new reservation or drop it on an overlapping write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            id_q    <= '0;
            first_q <= '0;
            last_q  <= '0;
        end else if (set_i) begin
            valid_o <= 1'b1;
            id_q    <= id_i;
            first_q <= first_i;
            last_q  <= last_i;
        end else if (wclr_i && overlap) begin
            valid_o <= 1'b0;
        end
    end

    // R5
    no_set_and_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_i && wclr_i));

    // R5
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wclr_i && overlap) |=> !valid_o);
endmodule

// File: rtl/excl_mon_alloc.sv
// Chooses the slot for a new reservation. The order is: the slot that already
// holds the ID, then the lowest free slot, then the victim pointer.
// Assumes NUM_ENT is at least 2 and that IDs are unique in the table.
module excl_mon_alloc #(
    parameter int NUM_ENT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_i,
    input  logic [NUM_ENT-1:0] valid_i,
    input  logic [NUM_ENT-1:0] hit_i,
    output logic [NUM_ENT-1:0] sel_o
);
    localparam int PTR_W = $clog2(NUM_ENT);

    logic [PTR_W-1:0] vptr_q;
    logic             evict;

    // Pick a one-hot slot for the allocation.
    always_comb begin
        sel_o = '0;
        evict = 1'b0;
        if (alloc_i) begin
            if (|hit_i) begin
                sel_o = hit_i;
            end else if (&valid_i) begin
                sel_o[vptr_q] = 1'b1;
                evict = 1'b1;
            end else begin
                for (int i = NUM_ENT - 1; i >= 0; i--) begin
                    if (!valid_i[i]) sel_o = NUM_ENT'(1) << i;
                end
            end
        end
    end

    // Move the victim pointer on after each eviction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vptr_q <= '0;
        end else if (evict) begin
            vptr_q <= (vptr_q == PTR_W'(NUM_ENT - 1)) ? '0 : vptr_q + 1'b1;
        end
    end

    // R9
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> $countones(sel_o) == 1);

    // R9
    no_free_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !(&valid_i) && !(|hit_i)) |-> (sel_o & valid_i) == '0);
endmodule

// File: rtl/excl_mon.sv
// Exclusive access reservation monitor. For each request it decides the
// response code and whether memory may be written, and it keeps the table of
// per-ID reservations. Responses are registered one cycle after the request.
// Assumes at most one request per cycle, and len is the byte count minus one.
module excl_mon
    import excl_mon_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int ID_W    = 4,
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 4,
    parameter bit EXCL_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_excl,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              mem_wr_en
);
    logic [ADDR_W:0]    first_a;
    logic [ADDR_W:0]    last_a;
    logic               ex_rd;
    logic               ex_wr;
    logic               ex_ok;
    logic               wr_allow;
    logic [NUM_ENT-1:0] ent_valid;
    logic [NUM_ENT-1:0] ent_hit;
    logic [NUM_ENT-1:0] ent_exact;
    logic [NUM_ENT-1:0] ent_set;
    rsp_e               code_d;

    // Decode the request and grade it.
    always_comb begin
        first_a  = {1'b0, req_addr};
        last_a   = first_a + (ADDR_W + 1)'(req_len);
        ex_rd    = EXCL_EN && req_valid && !req_write && req_excl;
        ex_wr    = EXCL_EN && req_valid && req_write && req_excl;
        ex_ok    = ex_wr && (|ent_exact);
        wr_allow = req_valid && req_write && (!(EXCL_EN && req_excl) || ex_ok);
        code_d   = (ex_rd || ex_ok) ? RSP_EXOKAY : RSP_OKAY;
    end

    excl_mon_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_i (ex_rd),
        .valid_i (ent_valid),
        .hit_i   (ent_hit),
        .sel_o   (ent_set)
    );

    generate
        for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
            excl_mon_entry #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_ent (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_i    (ent_set[g]),
                .wclr_i   (wr_allow),
                .id_i     (req_id),
                .first_i  (first_a),
                .last_i   (last_a),
                .valid_o  (ent_valid[g]),
                .id_hit_o (ent_hit[g]),
                .exact_o  (ent_exact[g])
            );
        end
    endgenerate

    // Register the response for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OKAY;
            mem_wr_en <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_code  <= req_valid ? code_d : RSP_OKAY;
            mem_wr_en <= wr_allow;
        end
    end

    // R6
    unique_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ent_hit));

    // R4
    wr_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> rsp_valid && $past(req_write));

    // R3
    fail_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_OKAY && $past(req_write && req_excl) && EXCL_EN)
            |-> !mem_wr_en);

    // R2
    exokay_write_updates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_EXOKAY && $past(req_write)) |-> mem_wr_en);

    // R10
    exokay_needs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code == RSP_EXOKAY) |-> (EXCL_EN && $past(req_excl && req_valid)));
endmodule

// File: tb/excl_mon_test.sv
module excl_mon_test;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_excl = 1'b0;
    logic [3:0] req_id = '0;
    logic [15:0] req_addr = '0;
    logic [3:0] req_len = '0;
    logic       rsp_valid, mem_wr_en, off_valid, off_wr_en;
    logic [1:0] rsp_code, off_code;

    int n_chk = 0;
    int n_bad = 0;

    // Reference table
    bit mv [NE];
    int mid [NE];
    int mfirst [NE];
    int mlast [NE];
    int mptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    excl_mon uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_excl(req_excl), .req_id(req_id), .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .mem_wr_en(mem_wr_en));

    excl_mon #(.EXCL_EN(1'b0)) uut_off (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_write(req_write), .req_excl(req_excl), .req_id(req_id), .req_addr(req_addr),
        .req_len(req_len), .rsp_valid(off_valid), .rsp_code(off_code), .mem_wr_en(off_wr_en));

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Model one request: returns expected code and write enable, updates table.
    task automatic model(input bit w, input bit ex, input int id, input int a,
                         input int len, output int code, output int we);
        int last = a + len;
        int hit = -1;
        bit ok = 0;
        for (int i = 0; i < NE; i++) if (mv[i] && mid[i] == id) hit = i;
        code = 0; we = 0;
        if (!w && ex) begin
            int s = hit;
            code = 1;
            if (s < 0) for (int i = NE - 1; i >= 0; i--) if (!mv[i]) s = i;
            if (s < 0) begin s = mptr; mptr = (mptr + 1) % NE; end
            mv[s] = 1; mid[s] = id; mfirst[s] = a; mlast[s] = last;
        end else if (w) begin
            if (ex) ok = (hit >= 0) && mfirst[hit] == a && mlast[hit] == last;
            we = (!ex || ok) ? 1 : 0;
            code = ok ? 1 : 0;
            if (we == 1)
                for (int i = 0; i < NE; i++)
                    if (mv[i] && mfirst[i] <= last && a <= mlast[i]) mv[i] = 0;
        end
    endtask

    task automatic access(input bit w, input bit ex, input int id, input int a,
                          input int len, input string tag);
        int code, we;
        model(w, ex, id, a, len, code, we);
        req_valid = 1; req_write = w; req_excl = ex;
        req_id = 4'(id); req_addr = 16'(a); req_len = 4'(len);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        check({tag, " valid R11"}, rsp_valid, 1);
        check({tag, " code"}, rsp_code, code);
        check({tag, " wr_en"}, mem_wr_en, we);
        if (ex) begin
            check("R10 off code", off_code, 0);
            check("R10 off wr_en", off_wr_en, w);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NE; i++) mv[i] = 0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 rsp_valid", rsp_valid, 0);
        check("R12 wr_en", mem_wr_en, 0);
        rst_n = 1;
        @(negedge clk);
        check("R11 idle valid", rsp_valid, 0);

        // R1 then R2 basic success
        access(0, 1, 1, 'h0000, 15, "R1 excl read");
        access(1, 1, 1, 'h0000, 15, "R2 excl write ok");
        access(1, 1, 1, 'h0000, 15, "R5 own reservation cleared R3");
        // R5 intervening write from another ID
        access(0, 1, 2, 'h0010, 15, "R1 read");
        access(1, 0, 3, 'h0018, 0, "R4 plain write");
        access(1, 1, 2, 'h0010, 15, "R5 broken R3");
        // R8 plain reads keep reservation; R3 off-by-one range
        access(0, 1, 4, 'h0020, 7, "R1 read");
        access(0, 0, 4, 'h0020, 7, "R4 R8 plain read");
        access(1, 1, 4, 'h0020, 8, "R3 range mismatch");
        access(1, 1, 4, 'h0020, 7, "R8 R2 still held");
        // R6 replace
        access(0, 1, 5, 'h0040, 3, "R1 read");
        access(0, 1, 5, 'h0050, 3, "R6 replace");
        access(1, 1, 5, 'h0040, 3, "R6 old range R3");
        access(1, 1, 5, 'h0050, 3, "R6 new range R2");
        // R7 two IDs same region
        access(0, 1, 6, 'h0060, 15, "R7 read a");
        access(0, 1, 7, 'h0060, 15, "R7 read b");
        access(1, 1, 6, 'h0060, 15, "R7 first wins R2");
        access(1, 1, 7, 'h0060, 15, "R7 R5 second lost");
        // R9 fill table and evict
        for (int i = 0; i < NE + 2; i++)
            access(0, 1, 8 + i, 'h100 + 16 * i, 15, "R9 fill");
        for (int i = 0; i < NE + 2; i++)
            access(1, 1, 8 + i, 'h100 + 16 * i, 15, "R9 after evict");
        // R3 no reservation at all
        access(1, 1, 15, 'h0200, 0, "R3 no entry");

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            bit w = 1'($urandom);
            bit ex = ($urandom % 4) != 0;
            int id = $urandom % 6;
            int a = ($urandom % 8) * 8;
            int len = $urandom % 16;
            if (w && ex && ($urandom % 3 == 0)) begin
                int k = $urandom % NE;
                if (mv[k]) begin id = mid[k]; a = mfirst[k]; len = mlast[k] - mfirst[k]; end
            end
            access(w, ex, id, a, len, "R2 R3 R5 R9 random");
            if ($urandom % 8 == 0) begin
                @(negedge clk);
                check("R11 gap valid", rsp_valid, 0);
            end
        end
        summary();
        $finish;
    end
endmodule